// File: doc/BRIEF.md
# USB Split Transaction Channel Sequencer

This block is one host channel that carries USB 2.0 split transactions to a full- or low-speed device sitting behind a high-speed hub. Software programs the direction, whether this phase is a start split or a complete split, the micro-frame parity to launch on, the largest packet in 32-bit words and a memory base address. It then pulses the enable. The channel asks the shared scheduler for a slot. It pushes its token request into the request queue in the cycle the grant arrives. It then waits for the start of a micro-frame with the selected parity and hands the token to the packet engine.

Once the token is out, the channel does one of three things. A start split IN, or a complete split OUT, ends at once. A start split OUT sends its data packet. A complete split IN streams each received word straight into a 32-bit memory write port that uses a valid/ready handshake, starting at the base address and stepping by four bytes. Every phase ends in a halted state with a sticky interrupt. Software clears that interrupt and reprograms the channel before the next phase. An isochronous OUT split therefore runs as two start split OUT phases in a row, a begin and an end. A receive packet longer than the programmed size is flagged as babble and stops the channel. A disable pulse halts the channel from any state.

Top module: `usb_split_chan`

## Requirements
- R1: While in the arbitration state the channel holds `arb_req` high; `rq_push` is high exactly in a cycle where `arb_req` and `arb_gnt` are both high, and `arb_req` is low in the following cycle.
- R2: After the grant, `tok_req` rises in the cycle after the first `uframe_stb` whose `uframe_odd` equals the latched `cfg_odd_sel` (1 = odd); strobes of the other parity are ignored.
- R3: For a start split IN (`cfg_dir_in`=1, `cfg_cplt`=0) and a complete split OUT (`cfg_dir_in`=0, `cfg_cplt`=1), `tok_done` moves the channel straight to halted with `halt_irq` set, with no data phase and no memory write.
- R4: For a complete split IN, after `tok_done` each accepted receive word is written at `cfg_base`, `cfg_base`+4, … in arrival order; `halt_irq` rises the cycle after the memory handshake of the word flagged `rx_last`.
- R5: For a start split OUT, `tx_req` is high from the cycle after `tok_done` until `tx_done`, after which the channel halts with `halt_irq` set; the begin and end phases of an isochronous OUT each raise their own interrupt.
- R6: `ch_en` is accepted only in the idle or halted state and latches the configuration (reflected on `tok_in` and `tok_cplt`); a pulse in any other state has no effect.
- R7: `halt_irq` is sticky; `irq_clr` clears it, but a halt in the same cycle wins and leaves it set.
- R8: While `mem_valid` is high and `mem_ready` low, `mem_valid`, `mem_addr` and `mem_data` hold.
- R9: A receive word arriving when the count of accepted words already equals `cfg_mps` sets `babble_err`, is not written, and halts the channel with `halt_irq`; `babble_err` clears when the next enable is accepted.
- R10: `ch_disable` moves the channel to halted with `halt_irq` set in the next cycle from any state, and has priority over `ch_en`.
- R11: After reset all request, ready and flag outputs are low and the channel is idle.
- R12: `rx_ready` is high only in the receive data state and only when the memory output stage is empty or being emptied in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_en | input | 1 | Enable pulse, starts a phase |
| ch_disable | input | 1 | Disable pulse, forces halt |
| irq_clr | input | 1 | Write-one-to-clear for the halt interrupt |
| cfg_dir_in | input | 1 | 1 = IN transfer, 0 = OUT |
| cfg_cplt | input | 1 | 1 = complete split, 0 = start split |
| cfg_odd_sel | input | 1 | Micro-frame parity to launch on (1 = odd) |
| cfg_mps | input | MPS_W | Largest packet in words |
| cfg_base | input | AW | Memory base byte address |
| arb_req | output | 1 | Request to the scheduler arbiter |
| arb_gnt | input | 1 | Grant from the arbiter |
| rq_push | output | 1 | Token request written into the request queue |
| uframe_stb | input | 1 | Micro-frame start strobe |
| uframe_odd | input | 1 | Parity of the micro-frame that starts |
| tok_req | output | 1 | Issue token phase |
| tok_in | output | 1 | Latched direction for the token |
| tok_cplt | output | 1 | Latched split kind for the token |
| tok_done | input | 1 | Token sent successfully |
| tx_req | output | 1 | Send OUT data packet |
| tx_done | input | 1 | OUT data packet finished |
| rx_valid | input | 1 | Receive word valid |
| rx_data | input | DW | Receive word |
| rx_last | input | 1 | Last word of the packet |
| rx_ready | output | 1 | Receive word accepted |
| mem_valid | output | 1 | Memory write valid |
| mem_ready | input | 1 | Memory write ready |
| mem_addr | output | AW | Memory byte address |
| mem_data | output | DW | Memory write word |
| halt_irq | output | 1 | Sticky channel-halted interrupt |
| babble_err | output | 1 | Receive packet exceeded the size limit |

## Verification
The bench builds the channel with a 16-bit address and a 4-bit size field. This keeps address compares short. It also lets the babble boundary be reached with limits of two to four words, both at the limit and one word past it. A micro-frame strobe every eight cycles with alternating parity makes both launch parities, and strobes that arrive during arbitration, occur in every phase. Random stalls on the memory ready and gaps in the receive valid push the output stage through its hold and drain paths. They also cover the case where the last word waits on memory before the interrupt.

// File: rtl/split_chan_pkg.sv
package split_chan_pkg;

    typedef enum logic [2:0] {
        CH_IDLE    = 3'd0,
        CH_ARB     = 3'd1,
        CH_WAIT_UF = 3'd2,
        CH_TOKEN   = 3'd3,
        CH_DATA_RX = 3'd4,
        CH_DATA_TX = 3'd5,
        CH_DMA_WR  = 3'd6,
        CH_HALT    = 3'd7
    } ch_state_e;

endpackage

// File: rtl/split_chan_qual.sv
module split_chan_qual #(
    parameter int MPS_W = 8
) (
    input  logic             uframe_stb,
    input  logic             uframe_odd,
    input  logic             want_odd,
    input  logic [MPS_W-1:0] word_cnt,
    input  logic [MPS_W-1:0] word_max,
    output logic             frame_hit,
    output logic             at_limit
);
    // launch point: a micro-frame start of the wanted parity
    assign frame_hit = uframe_stb && (uframe_odd == want_odd);
    // a further word would exceed the programmed packet size
    assign at_limit  = (word_cnt == word_max);
endmodule

// File: rtl/split_chan_wbuf.sv
module split_chan_wbuf #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_base,
    input  logic [AW-1:0] base,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    output logic          can_push,
    output logic          mem_valid,
    input  logic          mem_ready,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_data
);
    localparam logic [AW-1:0] STEP = AW'(DW / 8);

    typedef struct packed {
        logic          valid;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic [AW-1:0] nxt;
    } wb_t;

    wb_t wb_d, wb_q;

    always_comb begin
        wb_d = wb_q;
        if (wb_q.valid && mem_ready) begin
            wb_d.valid = 1'b0;
        end
        if (load_base) begin
            wb_d.nxt = base;
        end
        if (push) begin
            wb_d.valid = 1'b1;
            wb_d.addr  = wb_q.nxt;
            wb_d.data  = push_data;
            wb_d.nxt   = wb_q.nxt + STEP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wb_q <= '0;
        end else begin
            wb_q <= wb_d;
        end
    end

    assign can_push  = !wb_q.valid || mem_ready;
    assign mem_valid = wb_q.valid;
    assign mem_addr  = wb_q.addr;
    assign mem_data  = wb_q.data;
endmodule

// File: rtl/usb_split_chan.sv
module usb_split_chan
    import split_chan_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int MPS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ch_en,
    input  logic             ch_disable,
    input  logic             irq_clr,
    input  logic             cfg_dir_in,
    input  logic             cfg_cplt,
    input  logic             cfg_odd_sel,
    input  logic [MPS_W-1:0] cfg_mps,
    input  logic [AW-1:0]    cfg_base,
    output logic             arb_req,
    input  logic             arb_gnt,
    output logic             rq_push,
    input  logic             uframe_stb,
    input  logic             uframe_odd,
    output logic             tok_req,
    output logic             tok_in,
    output logic             tok_cplt,
    input  logic             tok_done,
    output logic             tx_req,
    input  logic             tx_done,
    input  logic             rx_valid,
    input  logic [DW-1:0]    rx_data,
    input  logic             rx_last,
    output logic             rx_ready,
    output logic             mem_valid,
    input  logic             mem_ready,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_data,
    output logic             halt_irq,
    output logic             babble_err
);
    typedef struct packed {
        ch_state_e        st;
        logic             dir_in;
        logic             cplt;
        logic             odd_sel;
        logic [MPS_W-1:0] mps;
        logic [MPS_W-1:0] cnt;
        logic             irq;
        logic             babble;
    } ch_t;

    ch_t  q, d;
    logic frame_hit, at_limit, can_push;
    logic load_base, push, set_irq;

    split_chan_qual #(.MPS_W(MPS_W)) u_qual (
        .uframe_stb (uframe_stb),
        .uframe_odd (uframe_odd),
        .want_odd   (q.odd_sel),
        .word_cnt   (q.cnt),
        .word_max   (q.mps),
        .frame_hit  (frame_hit),
        .at_limit   (at_limit)
    );

    split_chan_wbuf #(.AW(AW), .DW(DW)) u_wbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_base (load_base),
        .base      (cfg_base),
        .push      (push),
        .push_data (rx_data),
        .can_push  (can_push),
        .mem_valid (mem_valid),
        .mem_ready (mem_ready),
        .mem_addr  (mem_addr),
        .mem_data  (mem_data)
    );

    assign rx_ready = (q.st == CH_DATA_RX) && can_push;

    always_comb begin
        d         = q;
        load_base = 1'b0;
        push      = 1'b0;
        set_irq   = 1'b0;
        if (ch_disable) begin
            d.st    = CH_HALT;
            set_irq = 1'b1;
        end else begin
            unique case (q.st)
                CH_IDLE, CH_HALT: begin
                    if (ch_en) begin
                        d.st      = CH_ARB;
                        d.dir_in  = cfg_dir_in;
                        d.cplt    = cfg_cplt;
                        d.odd_sel = cfg_odd_sel;
                        d.mps     = cfg_mps;
                        d.cnt     = '0;
                        d.babble  = 1'b0;
                        load_base = 1'b1;
                    end
                end
                CH_ARB: begin
                    if (arb_gnt) d.st = CH_WAIT_UF;
                end
                CH_WAIT_UF: begin
                    if (frame_hit) d.st = CH_TOKEN;
                end
                CH_TOKEN: begin
                    if (tok_done) begin
                        if (q.dir_in && q.cplt) begin
                            d.st = CH_DATA_RX;
                        end else if (!q.dir_in && !q.cplt) begin
                            d.st = CH_DATA_TX;
                        end else begin
                            d.st    = CH_HALT;
                            set_irq = 1'b1;
                        end
                    end
                end
                CH_DATA_TX: begin
                    if (tx_done) begin
                        d.st    = CH_HALT;
                        set_irq = 1'b1;
                    end
                end
                CH_DATA_RX: begin
                    if (rx_valid && rx_ready) begin
                        if (at_limit) begin
                            d.babble = 1'b1;
                            d.st     = CH_HALT;
                            set_irq  = 1'b1;
                        end else begin
                            push  = 1'b1;
                            d.cnt = q.cnt + 1'b1;
                            if (rx_last) d.st = CH_DMA_WR;
                        end
                    end
                end
                CH_DMA_WR: begin
                    if (!mem_valid || mem_ready) begin
                        d.st    = CH_HALT;
                        set_irq = 1'b1;
                    end
                end
                default: d.st = CH_IDLE;
            endcase
        end
        if (set_irq) begin
            d.irq = 1'b1;
        end else if (irq_clr) begin
            d.irq = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: CH_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign arb_req    = (q.st == CH_ARB);
    assign rq_push    = (q.st == CH_ARB) && arb_gnt;
    assign tok_req    = (q.st == CH_TOKEN);
    assign tx_req     = (q.st == CH_DATA_TX);
    assign tok_in     = q.dir_in;
    assign tok_cplt   = q.cplt;
    assign halt_irq   = q.irq;
    assign babble_err = q.babble;
endmodule

// File: rtl/split_chan_chk.sv
module split_chan_chk #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          arb_req,
    input logic          rq_push,
    input logic          tok_req,
    input logic          uframe_stb,
    input logic          uframe_odd,
    input logic          odd_sel,
    input logic          tx_req,
    input logic          tx_done,
    input logic          ch_disable,
    input logic          irq_clr,
    input logic          halt_irq,
    input logic          babble_err,
    input logic          rx_ready,
    input logic          mem_valid,
    input logic          mem_ready,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_data
);
    AST_PUSH_ENDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rq_push |=> !arb_req); // R1

    AST_TOKEN_ON_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tok_req) |-> ($past(uframe_stb) && ($past(uframe_odd) == $past(odd_sel)))); // R2

    AST_TX_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && tx_done) |=> halt_irq); // R5

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_irq && !irq_clr) |=> halt_irq); // R7

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data))); // R8

    AST_BABBLE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(babble_err) |-> (!rx_ready && halt_irq)); // R9

    AST_DISABLE_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        ch_disable |=> (halt_irq && !arb_req && !tok_req && !tx_req)); // R10
endmodule

bind usb_split_chan split_chan_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .arb_req    (arb_req),
    .rq_push    (rq_push),
    .tok_req    (tok_req),
    .uframe_stb (uframe_stb),
    .uframe_odd (uframe_odd),
    .odd_sel    (q.odd_sel),
    .tx_req     (tx_req),
    .tx_done    (tx_done),
    .ch_disable (ch_disable),
    .irq_clr    (irq_clr),
    .halt_irq   (halt_irq),
    .babble_err (babble_err),
    .rx_ready   (rx_ready),
    .mem_valid  (mem_valid),
    .mem_ready  (mem_ready),
    .mem_addr   (mem_addr),
    .mem_data   (mem_data)
);

// File: tb/usb_split_chan_tb.sv
`timescale 1ns/1ps
module usb_split_chan_tb;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int MPS_W = 4;
    localparam int UF_PER = 8;

    // model phase codes (bench-local)
    localparam int P_IDLE = 0, P_ARB = 1, P_WAIT = 2, P_TOK = 3,
                   P_RX = 4, P_TX = 5, P_DRAIN = 6, P_HALT = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ch_en = 0, ch_disable = 0, irq_clr = 0;
    logic cfg_dir_in = 0, cfg_cplt = 0, cfg_odd_sel = 1;
    logic [MPS_W-1:0] cfg_mps = '0;
    logic [AW-1:0] cfg_base = '0;
    logic arb_req, rq_push, tok_req, tok_in, tok_cplt, tx_req, rx_ready;
    logic arb_gnt = 0, uframe_stb = 0, uframe_odd = 0, tok_done = 0, tx_done = 0;
    logic rx_valid = 0, rx_last = 0, mem_ready = 0;
    logic [DW-1:0] rx_data = '0;
    logic mem_valid, halt_irq, babble_err;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_data;

    always #4 clk = ~clk;

    usb_split_chan #(.AW(AW), .DW(DW), .MPS_W(MPS_W)) u_dut (.*);

    int n_cmp = 0, n_mis = 0;
    bit cmp_on = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_mis++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    int m_st = P_IDLE;
    bit m_in, m_cp, m_sel, m_irq, m_bab, m_mv, m_took;
    int m_mps, m_cnt;
    int m_addr, m_next;
    logic [DW-1:0] m_data;

    always @(posedge clk) begin
        int ns;
        bit seti, free;
        if (!rst_n) begin
            m_st = P_IDLE; m_in = 0; m_cp = 0; m_sel = 0; m_irq = 0; m_bab = 0;
            m_mv = 0; m_mps = 0; m_cnt = 0; m_addr = 0; m_next = 0; m_data = '0; m_took = 0;
        end else begin
            ns = m_st; seti = 0; m_took = 0;
            free = !m_mv || mem_ready;
            if (m_mv && mem_ready) m_mv = 0;
            if (ch_disable) begin
                ns = P_HALT; seti = 1;
            end else begin
                case (m_st)
                    P_IDLE, P_HALT: if (ch_en) begin
                        ns = P_ARB; m_in = cfg_dir_in; m_cp = cfg_cplt; m_sel = cfg_odd_sel;
                        m_mps = int'(cfg_mps); m_cnt = 0; m_bab = 0; m_next = int'(cfg_base);
                    end
                    P_ARB:  if (arb_gnt) ns = P_WAIT;
                    P_WAIT: if (uframe_stb && uframe_odd == m_sel) ns = P_TOK;
                    P_TOK:  if (tok_done) begin
                        if (m_in && m_cp) ns = P_RX;
                        else if (!m_in && !m_cp) ns = P_TX;
                        else begin ns = P_HALT; seti = 1; end
                    end
                    P_TX: if (tx_done) begin ns = P_HALT; seti = 1; end
                    P_RX: if (rx_valid && free) begin
                        m_took = 1;
                        if (m_cnt == m_mps) begin m_bab = 1; ns = P_HALT; seti = 1; end
                        else begin
                            m_mv = 1; m_addr = m_next; m_data = rx_data;
                            m_next = (m_next + 4) % (1 << AW); m_cnt++;
                            if (rx_last) ns = P_DRAIN;
                        end
                    end
                    P_DRAIN: if (free) begin ns = P_HALT; seti = 1; end
                    default: ;
                endcase
            end
            if (seti) m_irq = 1; else if (irq_clr) m_irq = 0;
            m_st = ns;
        end
    end

    // ---------------- responders ----------------
    int ufc = 0, gcnt = 0, tcnt = 0, xcnt = 0, gnt_lat = 2;
    int rx_left = 0, rx_idx = 0;
    bit rdy_all = 0, rx_dense = 0;
    logic [15:0] lfsr = 16'hACE1;

    always @(negedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        ufc = (ufc + 1) % UF_PER;
        uframe_stb <= (ufc == 0);
        if (ufc == 0) uframe_odd <= ~uframe_odd;
        gcnt = (m_st == P_ARB) ? gcnt + 1 : 0;
        arb_gnt <= (m_st == P_ARB) && (gcnt > gnt_lat);
        tcnt = (m_st == P_TOK) ? tcnt + 1 : 0;
        tok_done <= (m_st == P_TOK) && (tcnt > 2);
        xcnt = (m_st == P_TX) ? xcnt + 1 : 0;
        tx_done <= (m_st == P_TX) && (xcnt > 3);
        mem_ready <= rdy_all | lfsr[0];
        if (m_took && rx_left > 0) begin rx_left--; rx_idx++; end
        rx_valid <= (rx_left > 0) && (rx_dense | lfsr[3]);
        rx_last  <= (rx_left == 1);
        rx_data  <= 32'hD00D_0000 + rx_idx;
    end

    // ---------------- per-cycle compare ----------------
    int hs_cnt = 0;
    int hs_last = 0;
    bit prev_hit = 0, prev_tok = 0;

    task automatic cmp1(input string tag, input logic act, input bit exp, inout bit bad);
        if (act !== exp) begin
            bad = 1;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        #1;
        if (cmp_on) begin
            bit bad;
            bit e_rr;
            bad = 0;
            e_rr = (m_st == P_RX) && (!m_mv || mem_ready);
            n_cmp++;
            cmp1("R1 arb_req", arb_req, m_st == P_ARB, bad);
            cmp1("R1 rq_push", rq_push, (m_st == P_ARB) && arb_gnt, bad);
            cmp1("R2 tok_req", tok_req, m_st == P_TOK, bad);
            cmp1("R6 tok_in", tok_in, m_in, bad);
            cmp1("R6 tok_cplt", tok_cplt, m_cp, bad);
            cmp1("R5 tx_req", tx_req, m_st == P_TX, bad);
            cmp1("R12 rx_ready", rx_ready, e_rr, bad);
            cmp1("R7 halt_irq", halt_irq, m_irq, bad);
            cmp1("R9 babble_err", babble_err, m_bab, bad);
            cmp1("R8 mem_valid", mem_valid, m_mv, bad);
            if (m_mv && (mem_addr !== AW'(m_addr) || mem_data !== m_data)) begin
                bad = 1;
                $display("FAIL R4 mem addr/data actual=%0h/%0h expected=%0h/%0h at %0t",
                         mem_addr, mem_data, m_addr, m_data, $time);
            end
            if (bad) n_mis++;
            if (tok_req && !prev_tok)
                chk(prev_hit, "R2 token after matching strobe", prev_hit, 1);
            prev_tok = tok_req;
            prev_hit = uframe_stb && (uframe_odd == m_sel);
            if (mem_valid && mem_ready) begin hs_cnt++; hs_last = int'(mem_addr); end
        end
    end

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_mis++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
        $finish;
    end

    // ---------------- stimulus ----------------
    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clr_irq();
        irq_clr = 1; cyc(1); irq_clr = 0; cyc(1);
    endtask

    task automatic run_phase(input bit din, input bit cp, input bit sel,
                             input int mps, input int base, input int nw);
        hs_cnt = 0;
        cfg_dir_in = din; cfg_cplt = cp; cfg_odd_sel = sel;
        cfg_mps = MPS_W'(mps); cfg_base = AW'(base);
        rx_idx = 0;
        rx_left = (din && cp) ? nw : 0;
        ch_en = 1; cyc(1); ch_en = 0;
        for (int i = 0; i < 400 && m_st != P_HALT; i++) cyc(1);
        cyc(4);
        rx_left = 0;
        cyc(1);
    endtask

    initial begin
        cyc(4);
        rst_n = 1;
        cmp_on = 1;
        #2;
        chk(!arb_req && !tok_req && !tx_req && !rx_ready && !mem_valid && !halt_irq && !babble_err,
            "R11 reset outputs", {arb_req, tok_req, tx_req, rx_ready, mem_valid, halt_irq, babble_err}, 0);
        cyc(3);

        // start split IN, odd frames
        run_phase(1, 0, 1, 4, 'h40, 0);
        chk(halt_irq == 1, "R3 start split IN halts", halt_irq, 1);
        chk(hs_cnt == 0, "R3 no memory write", hs_cnt, 0);
        clr_irq();
        chk(halt_irq == 0, "R7 irq cleared", halt_irq, 0);

        // complete split IN, three words, random stalls
        run_phase(1, 1, 1, 4, 'h100, 3);
        chk(hs_cnt == 3, "R4 words written", hs_cnt, 3);
        chk(hs_last == 'h108, "R4 last address", hs_last, 'h108);
        chk(halt_irq == 1 && babble_err == 0, "R4 halt after write", {halt_irq, babble_err}, 2);
        clr_irq();

        // isochronous OUT: begin then end phase
        run_phase(0, 0, 1, 4, 0, 0);
        chk(halt_irq == 1, "R5 OUT begin phase halts", halt_irq, 1);
        clr_irq();
        run_phase(0, 0, 0, 4, 0, 0);
        chk(halt_irq == 1, "R5 OUT end phase halts", halt_irq, 1);
        clr_irq();

        // complete split OUT
        run_phase(0, 1, 0, 4, 0, 0);
        chk(halt_irq == 1 && hs_cnt == 0, "R3 complete split OUT halts", halt_irq, 1);
        clr_irq();

        // babble: limit 2, four words offered, full-rate memory
        rdy_all = 1; rx_dense = 1;
        run_phase(1, 1, 1, 2, 'h200, 4);
        chk(babble_err == 1, "R9 babble flagged", babble_err, 1);
        chk(hs_cnt == 2, "R9 extra word not written", hs_cnt, 2);
        clr_irq();

        // exactly at limit: no babble, flag cleared by enable
        rdy_all = 0; rx_dense = 0;
        run_phase(1, 1, 0, 2, 'h300, 2);
        chk(babble_err == 0, "R9 at limit no babble", babble_err, 0);
        chk(hs_cnt == 2 && hs_last == 'h304, "R4 at-limit writes", hs_last, 'h304);
        clr_irq();

        // enable while busy is ignored, then disable mid-wait
        gnt_lat = 10;
        cfg_dir_in = 1; cfg_cplt = 0; cfg_odd_sel = 1;
        ch_en = 1; cyc(1); ch_en = 0;
        cyc(2);
        cfg_dir_in = 0; cfg_cplt = 1;
        ch_en = 1; cyc(1); ch_en = 0;
        cyc(1);
        chk(tok_in == 1 && tok_cplt == 0, "R6 enable while busy ignored", {tok_in, tok_cplt}, 2);
        for (int i = 0; i < 100 && m_st != P_WAIT; i++) cyc(1);
        ch_disable = 1; cyc(1); ch_disable = 0;
        #2;
        chk(halt_irq == 1 && !arb_req && !tok_req, "R10 disable halts", halt_irq, 1);
        cyc(2);
        clr_irq();
        gnt_lat = 2;

        // disable and enable together: disable wins
        ch_en = 1; ch_disable = 1; cyc(1); ch_en = 0; ch_disable = 0;
        cyc(2);
        chk(!arb_req && halt_irq == 1, "R10 disable beats enable", arb_req, 0);
        clr_irq();

        // clear held across a halt: set wins, then clears
        irq_clr = 1;
        run_phase(1, 0, 0, 4, 0, 0);
        chk(halt_irq == 0, "R7 held clear after halt", halt_irq, 0);
        irq_clr = 0;
        cyc(4);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
        $finish;
    end
endmodule